// File: doc/BRIEF.md
# Delay-Line Sampling Phase Detector

This block is the digital phase detector of a clock-recovery loop for a serial link running at a medium data rate. The serial input runs down a chain of delay elements with equal delay per element. The block receives the outputs of all elements as one tap vector. On each rising edge of the recovered clock it takes a snapshot of that vector and looks for the point in the chain where the data changes value. It reports that position, measured from the middle of the chain, as a signed phase error. The physical chain, the oscillator and the analog filter lie outside the block.

The tap vector passes through two register stages on the recovered clock to reduce metastability. A combinational locator then finds the first adjacent pair of taps that differ, counting from tap 0. A registered stage turns that position into the error value, a valid flag and one-cycle up/down pulses that drive the external second-order loop filter. A lock tracker watches the stream of errors and raises a lock flag once the phase has stayed near the centre for long enough.

Top module: `tap_phase_detector`

## Requirements
- R1: A synchronous active-high reset clears `err_o`, `valid_o`, `up_o`, `dn_o` and `lock_o` to zero, and they stay at zero while reset is held.
- R2: A tap vector held on `taps_i` across a rising edge produces its result on the third rising edge after that edge's predecessor. The result is visible after the third rising edge that follows the cycle in which the vector was presented: two synchronizer stages, then one output register.
- R3: The transition index is the lowest i in 0..N_TAPS-2 for which tap i and tap i+1 differ. When several such pairs exist, the lowest index is used.
- R4: `err_o` is a two's-complement signed value equal to the transition index minus N_TAPS/2. With the default of 32 taps, a transition at index 16 gives 0, index 0 gives -16 and index 30 gives +14.
- R5: A snapshot with no adjacent pair that differs drives `valid_o` low, holds `err_o` at its previous value, and keeps both pulses low. Any snapshot that contains a transition drives `valid_o` high.
- R6: `up_o` is high for exactly the cycles whose result is valid with a positive error. `dn_o` is high for exactly the cycles whose result is valid with a negative error. A zero error raises neither pulse, and the two pulses are never high together.
- R7: `lock_o` rises together with the 16th consecutive valid result whose error magnitude is at most 1. A result that is invalid, or valid with magnitude 2, ends the run of qualifying results but does not clear `lock_o`.
- R8: A valid result with error magnitude greater than 2 clears `lock_o` in the same cycle that result appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered clock; all capture happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| taps_i | input | N_TAPS | Delay-chain tap outputs, tap 0 first along the chain |
| err_o | output | IDX_W+1 | Signed phase error, index minus N_TAPS/2 |
| valid_o | output | 1 | The current snapshot held a transition |
| up_o | output | 1 | One-cycle pulse on a positive error |
| dn_o | output | 1 | One-cycle pulse on a negative error |
| lock_o | output | 1 | Phase has stayed near the centre long enough |

## Verification
Every result of this block, including the error, valid flag, pulses and lock flag, becomes visible on the third rising edge after the cycle in which a tap vector is presented. Lock and hold behaviour build up from one result to the next with no extra delay. For this reason the driver gives every tap vector it presents a due cycle equal to the current cycle count plus three, and it queues the expected values it computes. The monitor samples on the falling edge and compares an item only when the cycle counter reaches that item's due cycle. Every clock cycle, including each idle gap before a reset, is driven through the task, so the bench's own model of the held error and the qualifying run never drifts away from the design.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

  // Magnitude of a signed phase error held in an int.
  function automatic int err_mag(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // Phase error from a transition index and a centre tap.
  function automatic int index_to_err(input int idx, input int centre);
    return idx - centre;
  endfunction

endpackage

// File: rtl/tpd_sync.sv
module tpd_sync #(
  parameter int N_TAPS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TAPS-1:0] taps_i,
  output logic [N_TAPS-1:0] snap_o
);

  // Two flops per tap on the recovered clock.
  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    logic [1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[0], taps_i[g]};
    end
    assign snap_o[g] = sh[1];
  end

endmodule

// File: rtl/tpd_locate.sv
module tpd_locate #(
  parameter int N_TAPS = 32,
  parameter int IDX_W  = $clog2(N_TAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TAPS-1:0] snap_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o
);

  // Adjacent-pair differences: bit i set when tap i and tap i+1 disagree.
  logic [N_TAPS-2:0] pair_diff;
  assign pair_diff = snap_i[N_TAPS-2:0] ^ snap_i[N_TAPS-1:1];

  // Scan from the far end so the pair nearest tap 0 wins.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N_TAPS - 2; i >= 0; i--) begin
      if (pair_diff[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  // R3: a reported index always points at a real edge in the snapshot.
  a_r3_found_is_edge: assert property (@(posedge clk) disable iff (rst)
    found_o |-> (snap_i[idx_o] != snap_i[idx_o + IDX_W'(1)]));

endmodule

// File: rtl/tpd_error.sv
module tpd_error #(
  parameter int IDX_W  = 5,
  parameter int ERR_W  = IDX_W + 1,
  parameter int CENTRE = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    found_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic signed [ERR_W-1:0] err_next_o,
  output logic signed [ERR_W-1:0] err_o,
  output logic                    valid_o,
  output logic                    up_o,
  output logic                    dn_o
);

  assign err_next_o = $signed({1'b0, idx_i}) - $signed(ERR_W'(CENTRE));

  always_ff @(posedge clk) begin
    if (rst) begin
      err_o   <= '0;
      valid_o <= 1'b0;
      up_o    <= 1'b0;
      dn_o    <= 1'b0;
    end else begin
      valid_o <= found_i;
      up_o    <= found_i && (err_next_o > 0);
      dn_o    <= found_i && (err_next_o < 0);
      if (found_i) err_o <= err_next_o;
    end
  end

  // R5: an empty snapshot holds the error and drops the valid flag.
  a_r5_hold_on_empty: assert property (@(posedge clk) disable iff (rst)
    !found_i |=> (!valid_o && $stable(err_o) && !up_o && !dn_o));

  // R6: pulses are exclusive and follow the sign of a valid error.
  a_r6_pulse_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({up_o, dn_o}));
  a_r6_up_on_pos: assert property (@(posedge clk) disable iff (rst)
    (valid_o && (err_o > 0)) |-> up_o);
  a_r6_dn_on_neg: assert property (@(posedge clk) disable iff (rst)
    (valid_o && (err_o < 0)) |-> dn_o);

endmodule

// File: rtl/tpd_lock.sv
module tpd_lock #(
  parameter int ERR_W      = 6,
  parameter int LOCK_RUN   = 16,
  parameter int LOCK_TOL   = 1,
  parameter int UNLOCK_TOL = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    found_i,
  input  logic signed [ERR_W-1:0] err_next_i,
  output logic                    lock_o
);
  import tpd_pkg::*;

  localparam int CNT_W = $clog2(LOCK_RUN + 1);

  logic [CNT_W-1:0] run_q;
  logic             qualify;
  logic             too_far;

  assign qualify = found_i && (err_mag(int'(err_next_i)) <= LOCK_TOL);
  assign too_far = found_i && (err_mag(int'(err_next_i)) > UNLOCK_TOL);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      lock_o <= 1'b0;
    end else if (qualify) begin
      if (int'(run_q) < LOCK_RUN) run_q <= run_q + CNT_W'(1);
      if (int'(run_q) + 1 >= LOCK_RUN) lock_o <= 1'b1;
    end else begin
      run_q <= '0;
      if (too_far) lock_o <= 1'b0;
    end
  end

endmodule

// File: rtl/tap_phase_detector.sv
module tap_phase_detector #(
  parameter int N_TAPS     = 32,
  parameter int LOCK_RUN   = 16,
  parameter int LOCK_TOL   = 1,
  parameter int UNLOCK_TOL = 2,
  localparam int IDX_W     = $clog2(N_TAPS),
  localparam int ERR_W     = IDX_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_TAPS-1:0]       taps_i,
  output logic signed [ERR_W-1:0] err_o,
  output logic                    valid_o,
  output logic                    up_o,
  output logic                    dn_o,
  output logic                    lock_o
);

  localparam int CENTRE = N_TAPS / 2;

  logic [N_TAPS-1:0]       snap;
  logic                    edge_found;
  logic [IDX_W-1:0]        edge_idx;
  logic signed [ERR_W-1:0] err_next;

  tpd_sync #(.N_TAPS(N_TAPS)) u_sync (
    .clk(clk), .rst(rst), .taps_i(taps_i), .snap_o(snap)
  );

  tpd_locate #(.N_TAPS(N_TAPS), .IDX_W(IDX_W)) u_locate (
    .clk(clk), .rst(rst), .snap_i(snap),
    .found_o(edge_found), .idx_o(edge_idx)
  );

  tpd_error #(.IDX_W(IDX_W), .ERR_W(ERR_W), .CENTRE(CENTRE)) u_error (
    .clk(clk), .rst(rst), .found_i(edge_found), .idx_i(edge_idx),
    .err_next_o(err_next), .err_o(err_o), .valid_o(valid_o),
    .up_o(up_o), .dn_o(dn_o)
  );

  tpd_lock #(
    .ERR_W(ERR_W), .LOCK_RUN(LOCK_RUN),
    .LOCK_TOL(LOCK_TOL), .UNLOCK_TOL(UNLOCK_TOL)
  ) u_lock (
    .clk(clk), .rst(rst), .found_i(edge_found),
    .err_next_i(err_next), .lock_o(lock_o)
  );

  // Output-side magnitude, used only by the checks below.
  logic [ERR_W-1:0] out_mag;
  assign out_mag = err_o[ERR_W-1] ? ERR_W'(-err_o) : ERR_W'(err_o);

  // R7: lock can only rise on a valid, near-centre result.
  a_r7_rise_near_centre: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> (valid_o && (out_mag <= ERR_W'(LOCK_TOL))));

  // R8: a valid result far from centre never shows lock.
  a_r8_clear_far: assert property (@(posedge clk) disable iff (rst)
    (valid_o && (out_mag > ERR_W'(UNLOCK_TOL))) |-> !lock_o);

endmodule

// File: tb/tap_phase_detector_tb.sv
module tap_phase_detector_tb;

  localparam int N      = 32;
  localparam int CENTRE = N / 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [N-1:0]      taps = '0;
  logic signed [5:0] err_o;
  logic              valid_o, up_o, dn_o, lock_o;

  always #5 clk = ~clk;

  tap_phase_detector u_dut (
    .clk(clk), .rst(rst), .taps_i(taps), .err_o(err_o),
    .valid_o(valid_o), .up_o(up_o), .dn_o(dn_o), .lock_o(lock_o)
  );

  typedef struct {
    int    due;
    int    err;
    bit    valid;
    bit    up;
    bit    dn;
    bit    lock;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;

  // Bench-side model state.
  int m_err = 0;
  int m_run = 0;
  bit m_lock = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Lowest index with differing neighbours, found via an xor-shift mask.
  function automatic int first_edge(input logic [N-1:0] t);
    logic [N-1:0] x;
    x = (t ^ (t >> 1)) & {1'b0, {(N-1){1'b1}}};
    for (int k = 0; k < N; k++) if (x[k]) return k;
    return -1;
  endfunction

  function automatic int absv(input int v);
    if (v < 0) return -v;
    return v;
  endfunction

  function automatic logic [N-1:0] edge_at(input int i);
    return (N'(1) << (i + 1)) - N'(1);
  endfunction

  task automatic drive(input logic [N-1:0] t, input string tag);
    exp_t e;
    int   k;
    @(negedge clk);
    taps = t;
    k = first_edge(t);
    e.valid = (k >= 0);
    if (e.valid) m_err = k - CENTRE;
    e.err = m_err;
    e.up  = e.valid && (m_err > 0);
    e.dn  = e.valid && (m_err < 0);
    if (e.valid && absv(m_err) <= 1) begin
      m_run++;
      if (m_run >= 16) m_lock = 1;
    end else begin
      m_run = 0;
      if (e.valid && absv(m_err) > 2) m_lock = 0;
    end
    e.lock = m_lock;
    e.due  = cyc + 3;
    e.tag  = tag;
    q.push_back(e);
  endtask

  // Monitor: compare each queued item in its due cycle.
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (int'(err_o) != e.err || valid_o !== e.valid || up_o !== e.up ||
          dn_o !== e.dn || lock_o !== e.lock) begin
        fails++;
        $display("FAIL %s: got err=%0d v=%0b up=%0b dn=%0b lock=%0b exp err=%0d v=%0b up=%0b dn=%0b lock=%0b",
                 e.tag, err_o, valid_o, up_o, dn_o, lock_o,
                 e.err, e.valid, e.up, e.dn, e.lock);
      end
    end
  end

  task automatic check_reset_state(input string tag);
    checks++;
    if (err_o !== 6'sd0 || valid_o !== 1'b0 || up_o !== 1'b0 ||
        dn_o !== 1'b0 || lock_o !== 1'b0) begin
      fails++;
      $display("FAIL %s: got err=%0d v=%0b up=%0b dn=%0b lock=%0b exp all zero",
               tag, err_o, valid_o, up_o, dn_o, lock_o);
    end
  endtask

  task automatic flush_and_reset();
    for (int k = 0; k < 3; k++) drive('0, "R5 idle");
    while (q.size() > 0) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state("R1 reset during run");
    rst = 1'b0;
    m_err = 0; m_run = 0; m_lock = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R1 initial reset");
    rst = 1'b0;

    // R2 R4 R6: sweep every edge position across the chain.
    for (int i = 0; i <= N - 2; i++) drive(edge_at(i), "R4 sweep");
    drive(edge_at(0),  "R4 index 0 gives -16");
    drive(edge_at(30), "R4 index 30 gives +14");
    drive(edge_at(16), "R6 centre no pulse");
    drive(~edge_at(20), "R6 inverted polarity");

    // R5: no transition holds the error.
    drive(edge_at(22), "R5 setup");
    drive('0, "R5 all zero");
    drive('1, "R5 all ones");
    drive(edge_at(9), "R5 resume");

    // R3: several transitions, lowest wins.
    drive(32'h0000_0F0F, "R3 two pulses");
    drive(32'hAAAA_AAAA, "R3 alternating");
    drive(32'hFFFF_0000, "R3 single high edge");
    drive(32'h8000_0001, "R3 ends only");

    // R2: one-cycle pulse between two empty snapshots.
    drive('0, "R2 pre");
    drive(edge_at(5), "R2 single vector");
    drive('0, "R2 post");

    // R7: build lock with errors in -1..+1.
    for (int k = 0; k < 16; k++)
      drive(edge_at(15 + (k % 3)), "R7 lock build");
    drive(edge_at(18), "R7 error 2 keeps lock");
    drive('1, "R7 empty keeps lock");
    for (int k = 0; k < 15; k++) drive(edge_at(16), "R7 run of 15");
    drive(edge_at(19), "R8 error 3 clears lock");
    for (int k = 0; k < 15; k++) drive(edge_at(16), "R7 no lock at 15");
    drive(edge_at(14), "R7 error -2 breaks run");
    for (int k = 0; k < 16; k++) drive(edge_at(17), "R7 relock");
    drive(edge_at(12), "R8 error -4 clears lock");
    for (int k = 0; k < 16; k++) drive(edge_at(16), "R7 lock before reset");

    // R1: reset clears a held lock and error.
    flush_and_reset();
    drive(edge_at(20), "R1 after reset");
    drive('0, "R1 hold after reset");

    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got no completion, exp finish before 20000 cycles");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

endmodule